// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit sits beside a packet-based serial bus master and turns its transfer events into one interrupt line. Six event sources (packet complete, all packets complete, transmit overflow, receive underflow, missing acknowledge, arbitration lost) arrive as single-cycle pulses. Each pulse latches a sticky bit in an 8-bit status word. Two further status bits are not stored: they track the live transmit and receive FIFO request levels. Software clears sticky bits by writing ones. A mask register selects which status bits may raise the interrupt line. The packet-complete bit raises the line whatever its mask bit holds.

For a controller variant that sits inside a wrapper, an optional wrapper status word carries one done flag. The flag is set in any cycle in which the interrupt line is high, and software clears it by writing a one. A two-bit read select steers the status word, the mask word or the wrapper word onto one read bus. Write strobes for status, mask and wrapper share one write data bus.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset the sticky status bits, the mask register and the wrapper done flag are all zero, and the interrupt line is low while the FIFO request levels are low.
- R2: A pulse on evt_pulse[k] sets status bit k+2 at the next rising clock edge, and the bit stays set until it is cleared by software. The mapping is: bit 7 packet complete (evt_pulse[5]), bit 6 all packets complete (evt_pulse[4]), bit 5 transmit overflow (evt_pulse[3]), bit 4 receive underflow (evt_pulse[2]), bit 3 missing acknowledge (evt_pulse[1]), bit 2 arbitration lost (evt_pulse[0]).
- R3: A status write clears each sticky bit whose wr_data bit is 1 and leaves unchanged each sticky bit whose wr_data bit is 0.
- R4: When an event pulse and a write-1 clear hit the same sticky bit in the same cycle, the bit ends up set.
- R5: Status bit 1 equals tx_req_lvl and status bit 0 equals rx_req_lvl in the same cycle, and status writes have no effect on these two bits.
- R6: irq is the OR of all bits of (status AND mask), ORed with status bit 7. Bit 7 drives irq even when mask bit 7 is 0.
- R7: A mask write stores wr_data[7:0]. Bits 31:8 of the status word and of the mask word read as zero.
- R8: The wrapper done flag, read at bit 30 of the wrapper word, is set at the clock edge that follows a cycle in which irq is high. A wrapper write with wr_data[30]=1 clears the flag, but a set in the same cycle wins. All other bits of the wrapper word read as zero.
- R9: rd_sel encodes the read source: 0 status word, 1 mask word, 2 wrapper word, 3 all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 6 | Single-cycle event pulses, [5] packet complete down to [0] arbitration lost |
| tx_req_lvl | input | 1 | Live transmit FIFO request level |
| rx_req_lvl | input | 1 | Live receive FIFO request level |
| stat_wr | input | 1 | Write-1-to-clear strobe for the status word |
| mask_wr | input | 1 | Write strobe for the mask word |
| wrap_wr | input | 1 | Write-1-to-clear strobe for the wrapper word |
| wr_data | input | 32 | Write data shared by all three strobes |
| rd_sel | input | 2 | Read source select |
| rd_data | output | 32 | Selected word, combinational |
| irq | output | 1 | Interrupt line |

## Verification
A sticky bit shows up one rising edge after its pulse, and irq follows in the same cycle because it is combinational from the status and mask registers. The live request bits and the read bus respond within the same cycle as their inputs. The wrapper flag lags irq by one more edge. The bench changes inputs on falling edges and samples one time unit after the next falling edge, so every check falls in the first cycle in which its result is due. The wrapper checks look both one cycle early, when the flag must still be clear, and at the due cycle.

// File: rtl/isu_pkg.sv
// Package: shared read-select encoding and field geometry for the
// interrupt status unit. Assumes the status word has two live FIFO
// request bits at its bottom.
package isu_pkg;

    // Read source select encoding (R9)
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_WRAP   = 2'd2,
        SEL_NONE   = 2'd3
    } isu_sel_e;

    // Number of live (unstored) request bits at the bottom of the status word
    localparam int unsigned LIVE_BITS = 2;

endpackage

// File: rtl/isu_sticky_bank.sv
// Module: isu_sticky_bank
// A bank of independent sticky flags. Each flag sets on its set input and
// clears on its clear input; set has priority. Assumes set inputs are
// single-cycle pulses or levels already qualified by the caller.
module isu_sticky_bank #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_flag
            logic flag_q;

            // Hold, clear or set one flag; a set beats a clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (set_i[gi]) begin
                    flag_q <= 1'b1;
                end else if (clr_i[gi]) begin
                    flag_q <= 1'b0;
                end
            end

            assign q_o[gi] = flag_q;
        end
    endgenerate

endmodule

// File: rtl/isu_mask_reg.sv
// Module: isu_mask_reg
// Plain writable enable register for the interrupt sources. Resets to all
// zeros so that every maskable source starts disabled.
module isu_mask_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    // Load the mask on a write strobe, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (we_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/isu_irq_merge.sv
// Module: isu_irq_merge
// Combines status and mask into the interrupt line. The top status bit
// bypasses its mask. Purely combinational; assumes both inputs are
// registered or stable within the cycle.
module isu_irq_merge #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             irq_o
);

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] enabled;

    // Gate every bit by its mask, then OR in the unmaskable top bit.
    always_comb begin
        enabled = status_i & mask_i;
        irq_o   = (|enabled) | status_i[TOP];
    end

endmodule

// File: rtl/irq_status_unit.sv
// Module: irq_status_unit
// Interrupt status and mask unit for a packet-based serial bus master.
// Six event pulses latch sticky status bits (write 1 to clear), two FIFO
// request levels appear live in the low status bits, a mask register
// gates the interrupt line, and the top sticky bit is unmaskable. An
// optional wrapper done flag records that the interrupt line was high.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module irq_status_unit #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned N_STICKY = 6,
    parameter int unsigned WRAP_BIT = 30,
    parameter bit          WRAP_EN  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STICKY-1:0] evt_pulse,
    input  logic                tx_req_lvl,
    input  logic                rx_req_lvl,
    input  logic                stat_wr,
    input  logic                mask_wr,
    input  logic                wrap_wr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [1:0]          rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq
);

    import isu_pkg::*;

    localparam int unsigned N_LIVE = LIVE_BITS;
    localparam int unsigned STAT_W = N_STICKY + N_LIVE;
    localparam int unsigned PAD_W  = DATA_W - STAT_W;

    logic [N_STICKY-1:0] sticky_q;
    logic [N_STICKY-1:0] sticky_clr;
    logic [STAT_W-1:0]   stat_word;
    logic [STAT_W-1:0]   mask_q;
    logic                wrap_q;
    logic [DATA_W-1:0]   wrap_word;
    logic                unused_wr_bits;

    // Derive the write-1 clear vector for the sticky bits.
    always_comb begin
        sticky_clr = stat_wr ? wr_data[STAT_W-1:N_LIVE] : '0;
    end

    isu_sticky_bank #(
        .WIDTH (N_STICKY)
    ) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_pulse),
        .clr_i (sticky_clr),
        .q_o   (sticky_q)
    );

    // Assemble the status word: stored events above, live levels below.
    always_comb begin
        stat_word = {sticky_q, tx_req_lvl, rx_req_lvl};
    end

    isu_mask_reg #(
        .WIDTH (STAT_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (mask_wr),
        .d_i   (wr_data[STAT_W-1:0]),
        .q_o   (mask_q)
    );

    isu_irq_merge #(
        .WIDTH (STAT_W)
    ) u_merge (
        .status_i (stat_word),
        .mask_i   (mask_q),
        .irq_o    (irq)
    );

    generate
        if (WRAP_EN) begin : g_wrap
            logic wrap_clr;
            logic wrap_flag;

            // Clear request for the wrapper flag.
            always_comb begin
                wrap_clr = wrap_wr & wr_data[WRAP_BIT];
            end

            isu_sticky_bank #(
                .WIDTH (1)
            ) u_wrap (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (irq),
                .clr_i (wrap_clr),
                .q_o   (wrap_flag)
            );

            assign wrap_q = wrap_flag;
        end else begin : g_no_wrap
            assign wrap_q = 1'b0;
        end
    endgenerate

    // Place the wrapper flag at its bit position.
    always_comb begin
        wrap_word           = '0;
        wrap_word[WRAP_BIT] = wrap_q;
    end

    // Steer the selected word onto the read bus.
    always_comb begin
        case (isu_sel_e'(rd_sel))
            SEL_STATUS: rd_data = {{PAD_W{1'b0}}, stat_word};
            SEL_MASK:   rd_data = {{PAD_W{1'b0}}, mask_q};
            SEL_WRAP:   rd_data = wrap_word;
            default:    rd_data = '0;
        endcase
    end

    assign unused_wr_bits = ^{wr_data, wrap_wr};

endmodule

// Module: isu_checker
// Temporal checks on the interrupt status unit, bound into every instance.
module isu_checker #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned N_STICKY = 6,
    parameter bit          WRAP_EN  = 1'b1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [N_STICKY-1:0]          evt_pulse,
    input logic                         tx_req_lvl,
    input logic                         rx_req_lvl,
    input logic                         stat_wr,
    input logic [DATA_W-1:0]            wr_data,
    input logic [N_STICKY+1:0]          stat_word,
    input logic [N_STICKY+1:0]          mask_q,
    input logic                         wrap_q,
    input logic [1:0]                   rd_sel,
    input logic [DATA_W-1:0]            rd_data,
    input logic                         irq
);

    localparam int unsigned STAT_W = N_STICKY + 2;

    logic [N_STICKY-1:0] stk;
    logic [N_STICKY-1:0] clr_req;

    always_comb begin
        stk     = stat_word[STAT_W-1:2];
        clr_req = stat_wr ? wr_data[STAT_W-1:2] : '0;
    end

    // R2: every pulsed source shows as set one edge later
    p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((stk & $past(evt_pulse)) == $past(evt_pulse)));

    // R3: a set bit drops only where a one was written
    p_hold_unless_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stk) & ~$past(clr_req)) & ~stk) == '0));

    // R5: low status bits track the request levels
    p_live_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (stat_word[1:0] == {tx_req_lvl, rx_req_lvl}));

    // R6: packet complete raises the line regardless of mask
    p_unmaskable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[STAT_W-1] |-> irq);

    // R6: no enabled source and no packet complete keeps the line low
    p_quiet_when_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_word[STAT_W-1] && ((stat_word & mask_q) == '0)) |-> !irq);

    // R7: upper bits of status and mask read zero
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel != 2'd2) |-> (rd_data[DATA_W-1:STAT_W] == '0));

    generate
        if (WRAP_EN) begin : g_wrap_chk
            // R8: a high interrupt line sets the wrapper flag next edge
            p_wrap_follows_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
                irq |=> wrap_q);
        end
    endgenerate

endmodule

bind irq_status_unit isu_checker #(
    .DATA_W   (DATA_W),
    .N_STICKY (N_STICKY),
    .WRAP_EN  (WRAP_EN)
) u_isu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_pulse  (evt_pulse),
    .tx_req_lvl (tx_req_lvl),
    .rx_req_lvl (rx_req_lvl),
    .stat_wr    (stat_wr),
    .wr_data    (wr_data),
    .stat_word  (stat_word),
    .mask_q     (mask_q),
    .wrap_q     (wrap_q),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .irq        (irq)
);

// File: tb/test_irq_status_unit.sv
// Bench for irq_status_unit: directed corner cases, then a sweep over all
// mask values and all event patterns with arithmetic expectations.
module test_irq_status_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  evt_pulse;
    logic        tx_req_lvl, rx_req_lvl;
    logic        stat_wr, mask_wr, wrap_wr;
    logic [31:0] wr_data;
    logic [1:0]  rd_sel;
    logic [31:0] rd_data;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_status_unit i_irq_status_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_pulse  (evt_pulse),
        .tx_req_lvl (tx_req_lvl),
        .rx_req_lvl (rx_req_lvl),
        .stat_wr    (stat_wr),
        .mask_wr    (mask_wr),
        .wrap_wr    (wrap_wr),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_word(input logic [1:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    // Advance to the next falling edge with all strobes idle.
    task automatic idle_cycle();
        @(negedge clk);
        evt_pulse = '0; stat_wr = 1'b0; mask_wr = 1'b0; wrap_wr = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; evt_pulse = '0; tx_req_lvl = 1'b0; rx_req_lvl = 1'b0;
        stat_wr = 1'b0; mask_wr = 1'b0; wrap_wr = 1'b0; wr_data = '0; rd_sel = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        read_word(2'd0, v); check("R1 status", v, 32'h0);
        read_word(2'd1, v); check("R1 mask", v, 32'h0);
        read_word(2'd2, v); check("R1 wrap", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2: pulse missing-ack and rx-underflow sources
        @(negedge clk); evt_pulse = 6'b000110;
        idle_cycle(); #1;
        read_word(2'd0, v); check("R2 set", v, 32'h18);
        idle_cycle(); idle_cycle(); #1;
        read_word(2'd0, v); check("R2 sticky", v, 32'h18);

        // R3: write zero keeps, write one clears only that bit
        @(negedge clk); stat_wr = 1'b1; wr_data = 32'h0;
        idle_cycle(); #1;
        read_word(2'd0, v); check("R3 write zero", v, 32'h18);
        @(negedge clk); stat_wr = 1'b1; wr_data = 32'h08;
        idle_cycle(); #1;
        read_word(2'd0, v); check("R3 write one", v, 32'h10);

        // R4: set and clear on the same bit in one cycle
        @(negedge clk); stat_wr = 1'b1; wr_data = 32'h04; evt_pulse = 6'b000001;
        idle_cycle(); #1;
        read_word(2'd0, v); check("R4 set wins", v, 32'h14);
        @(negedge clk); stat_wr = 1'b1; wr_data = 32'hFF;
        idle_cycle(); #1;
        read_word(2'd0, v); check("R3 clear all", v, 32'h0);

        // R5: live levels appear at once and ignore writes
        @(negedge clk); tx_req_lvl = 1'b1; #1;
        read_word(2'd0, v); check("R5 tx level", v, 32'h2);
        stat_wr = 1'b1; wr_data = 32'h03;
        idle_cycle(); #1;
        read_word(2'd0, v); check("R5 write ignored", v, 32'h2);
        tx_req_lvl = 1'b0; rx_req_lvl = 1'b1; #1;
        read_word(2'd0, v); check("R5 rx level", v, 32'h1);
        rx_req_lvl = 1'b0;

        // R6: packet complete raises irq with mask all zero
        @(negedge clk); evt_pulse = 6'b100000;
        idle_cycle(); #1;
        check("R6 unmaskable", {31'b0, irq}, 32'h1);
        @(negedge clk); stat_wr = 1'b1; wr_data = 32'hFF;
        idle_cycle(); #1;
        check("R6 cleared", {31'b0, irq}, 32'h0);

        // R7: mask stores low byte only
        @(negedge clk); mask_wr = 1'b1; wr_data = 32'hFFFF_FFFF;
        idle_cycle(); #1;
        read_word(2'd1, v); check("R7 mask width", v, 32'h0000_00FF);
        @(negedge clk); mask_wr = 1'b1; wr_data = 32'h0;
        idle_cycle(); #1;
        read_word(2'd1, v); check("R7 mask zero", v, 32'h0);

        // R8: wrapper flag, irq now low
        @(negedge clk); wrap_wr = 1'b1; wr_data = 32'hFFFF_FFFF;
        idle_cycle(); #1;
        read_word(2'd2, v); check("R8 wrap cleared", v, 32'h0);
        @(negedge clk); evt_pulse = 6'b100000;
        idle_cycle(); #1;
        read_word(2'd2, v); check("R8 wrap not yet", v, 32'h0);
        idle_cycle(); #1;
        read_word(2'd2, v); check("R8 wrap set", v, 32'h4000_0000);
        @(negedge clk); stat_wr = 1'b1; wrap_wr = 1'b1; wr_data = 32'hFFFF_FFFF;
        idle_cycle(); #1;
        read_word(2'd2, v); check("R8 wrap set wins", v, 32'h4000_0000);
        @(negedge clk); wrap_wr = 1'b1; wr_data = 32'h4000_0000;
        idle_cycle(); #1;
        read_word(2'd2, v); check("R8 wrap clear", v, 32'h0);

        // R9: unused select reads zero
        @(negedge clk); evt_pulse = 6'b111111; tx_req_lvl = 1'b1;
        idle_cycle(); #1;
        read_word(2'd3, v); check("R9 select none", v, 32'h0);
        read_word(2'd0, v); check("R9 select status", v, 32'hFE);
        tx_req_lvl = 1'b0;

        // Sweep: every mask value against every event pattern (R2, R5, R6)
        for (int m = 0; m < 256; m++) begin
            @(negedge clk); evt_pulse = '0; mask_wr = 1'b1; wr_data = 32'(m);
            idle_cycle(); #1;
            read_word(2'd1, v); check("R7 sweep mask", v, 32'(m));
            for (int e = 0; e < 64; e++) begin
                logic [7:0] exp_stat;
                logic       exp_irq;
                @(negedge clk); stat_wr = 1'b1; wr_data = 32'hFF;
                @(negedge clk); stat_wr = 1'b0; wr_data = '0;
                evt_pulse = 6'(e); tx_req_lvl = e[1]; rx_req_lvl = e[0];
                @(negedge clk); evt_pulse = '0;
                #1;
                exp_stat = {6'(e), 2'(e)};
                exp_irq  = (|(exp_stat & 8'(m))) | exp_stat[7];
                read_word(2'd0, v); check("R2 R5 sweep status", v, {24'b0, exp_stat});
                check("R6 sweep irq", {31'b0, irq}, {31'b0, exp_irq});
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule